// File: doc/BRIEF.md
# Integer Arithmetic-Logic Unit

This block is the arithmetic and logic stage of a simple integer datapath. It takes two operand words and a 4-bit operation code. It produces a result word, a carry flag and an overflow flag, all captured in output registers one clock after the operands are presented. The operations are add, subtract, AND, OR, XOR and NOR.

The datapath is a chain of one-bit slices. A small decoder turns the operation code into three things: the function each slice selects, whether the second operand is inverted, and the carry fed into the lowest slice. Subtraction is the first operand plus the inverted second operand, with an incoming carry of one. NOR reuses the XOR path: the OR of the two bits is XORed with a constant one.

Extra logic at the top slice compares the carry entering the sign bit with the carry leaving it to detect signed overflow. A separate `signed_en` input decides whether add and subtract are treated as signed. When it is low, overflow is never reported. The surrounding pipeline drives it low for the unsigned add and subtract forms.

Top module: `int_alu`

## Requirements
- R1: While `rst` is high at a rising clock edge, `result_o`, `carry_o` and `ovf_o` are all cleared to 0 at that edge.
- R2: When `rst` is low, the outputs after a rising edge reflect the operands, code and `signed_en` sampled at that edge, and they hold until the next edge.
- R3: Code 2 (add) gives `result_o` = (`opa` + `opb`) mod 2^WIDTH, and `carry_o` = the carry out of the top bit of that sum.
- R4: Code 6 (subtract) gives `result_o` = (`opa` - `opb`) mod 2^WIDTH, and `carry_o` = 1 exactly when `opa` >= `opb` as unsigned numbers.
- R5: Code 0 gives the bitwise AND and code 1 gives the bitwise OR; for both, `carry_o` is 0.
- R6: Code 3 gives the bitwise XOR and code 4 gives the bitwise NOR; for both, `carry_o` is 0.
- R7: With `signed_en` = 1, `ovf_o` is 1 for add when both operands have the same sign bit and the result's sign bit differs from it. It is 1 for subtract when the operand sign bits differ and the result's sign bit differs from `opa`'s. Otherwise it is 0.
- R8: With `signed_en` = 0, `ovf_o` is 0 for every code and every operand pair.
- R9: For codes 0, 1, 3 and 4, `ovf_o` is 0 even when `signed_en` = 1.
- R10: Codes 5 and 7 to 15 are unused; they give `result_o` = 0, `carry_o` = 0 and `ovf_o` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every output changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| op_code | input | 4 | Operation code: 0 AND, 1 OR, 2 add, 3 XOR, 4 NOR, 6 subtract |
| signed_en | input | 1 | 1 treats add/subtract as signed and enables overflow |
| opa | input | WIDTH (32) | First operand |
| opb | input | WIDTH (32) | Second operand |
| result_o | output | WIDTH (32) | Registered result |
| carry_o | output | 1 | Registered carry out of the top slice (add/subtract only) |
| ovf_o | output | 1 | Registered signed overflow flag |

## Verification
The only state is the output register, so a wrong slice function, a broken carry link or a bad decode shows up at the ports on the clock edge right after the offending operands. No later cycle is needed to expose it. Carry-chain faults need operands that ripple a carry across long runs of ones, such as all-ones plus one or the most negative value minus one. Overflow faults need operand pairs on both sides of the signed limits, with `signed_en` toggled. Each such fault is then visible in the same cycle as a wrong `carry_o` or `ovf_o` next to an otherwise plausible result.

// File: rtl/int_alu_pkg.sv
package int_alu_pkg;

  localparam int OP_W = 4;

  localparam logic [OP_W-1:0] OPC_AND = 4'd0;
  localparam logic [OP_W-1:0] OPC_OR  = 4'd1;
  localparam logic [OP_W-1:0] OPC_ADD = 4'd2;
  localparam logic [OP_W-1:0] OPC_XOR = 4'd3;
  localparam logic [OP_W-1:0] OPC_NOR = 4'd4;
  localparam logic [OP_W-1:0] OPC_SUB = 4'd6;

  // function picked inside every one-bit slice
  typedef enum logic [1:0] {
    FN_AND = 2'd0,
    FN_OR  = 2'd1,
    FN_SUM = 2'd2,
    FN_XR  = 2'd3
  } slice_fn_e;

  typedef struct packed {
    slice_fn_e fn;
    logic      b_inv;     // invert second operand in every slice
    logic      c_first;   // carry into slice 0
    logic      nor_mode;  // XOR path computes (a|b)^1
    logic      arith;     // add or subtract
    logic      legal;     // code is one of the six used codes
  } alu_ctrl_t;

endpackage

// File: rtl/alu_decode.sv
module alu_decode
  import int_alu_pkg::*;
(
  input  logic [OP_W-1:0] op_code,
  output alu_ctrl_t       ctrl
);

  always_comb begin
    ctrl = '{fn: FN_AND, b_inv: 1'b0, c_first: 1'b0,
             nor_mode: 1'b0, arith: 1'b0, legal: 1'b0};
    case (op_code)
      OPC_AND: begin
        ctrl.fn    = FN_AND;
        ctrl.legal = 1'b1;
      end
      OPC_OR: begin
        ctrl.fn    = FN_OR;
        ctrl.legal = 1'b1;
      end
      OPC_ADD: begin
        ctrl.fn    = FN_SUM;
        ctrl.arith = 1'b1;
        ctrl.legal = 1'b1;
      end
      OPC_SUB: begin
        ctrl.fn      = FN_SUM;
        ctrl.b_inv   = 1'b1;
        ctrl.c_first = 1'b1;
        ctrl.arith   = 1'b1;
        ctrl.legal   = 1'b1;
      end
      OPC_XOR: begin
        ctrl.fn    = FN_XR;
        ctrl.legal = 1'b1;
      end
      OPC_NOR: begin
        ctrl.fn       = FN_XR;
        ctrl.nor_mode = 1'b1;
        ctrl.legal    = 1'b1;
      end
      default: ctrl.legal = 1'b0;
    endcase
  end

endmodule

// File: rtl/alu_bit_slice.sv
module alu_bit_slice
  import int_alu_pkg::*;
(
  input  logic      a_i,
  input  logic      b_i,
  input  logic      c_i,
  input  slice_fn_e fn,
  input  logic      b_inv,
  input  logic      nor_mode,
  output logic      r_o,
  output logic      c_o
);

  logic b_eff;
  logic and_v;
  logic or_v;
  logic sum_v;
  logic xr_l;
  logic xr_r;
  logic xr_v;

  assign b_eff = b_i ^ b_inv;
  assign and_v = a_i & b_eff;
  assign or_v  = a_i | b_eff;
  assign sum_v = a_i ^ b_eff ^ c_i;
  assign c_o   = and_v | (c_i & (a_i ^ b_eff));

  // shared XOR gate: plain XOR, or OR result flipped by a constant one
  assign xr_l = nor_mode ? or_v : a_i;
  assign xr_r = nor_mode ? 1'b1 : b_eff;
  assign xr_v = xr_l ^ xr_r;

  always_comb begin
    case (fn)
      FN_AND:  r_o = and_v;
      FN_OR:   r_o = or_v;
      FN_SUM:  r_o = sum_v;
      default: r_o = xr_v;
    endcase
  end

endmodule

// File: rtl/alu_ovf_flag.sv
module alu_ovf_flag (
  input  logic c_into_top,
  input  logic c_out_top,
  input  logic arith,
  input  logic signed_en,
  output logic ovf
);

  assign ovf = arith & signed_en & (c_into_top ^ c_out_top);

endmodule

// File: rtl/int_alu.sv
module int_alu
  import int_alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [OP_W-1:0]  op_code,
  input  logic             signed_en,
  input  logic [WIDTH-1:0] opa,
  input  logic [WIDTH-1:0] opb,
  output logic [WIDTH-1:0] result_o,
  output logic             carry_o,
  output logic             ovf_o
);

  localparam int TOP = WIDTH - 1;

  alu_ctrl_t        ctrl;
  logic [WIDTH:0]   chain;
  logic [WIDTH-1:0] slice_r;
  logic [WIDTH-1:0] res_d;
  logic             carry_d;
  logic             ovf_d;

  alu_decode u_dec (
    .op_code (op_code),
    .ctrl    (ctrl)
  );

  assign chain[0] = ctrl.c_first;

  for (genvar i = 0; i < WIDTH; i++) begin : g_slice
    alu_bit_slice u_bit (
      .a_i      (opa[i]),
      .b_i      (opb[i]),
      .c_i      (chain[i]),
      .fn       (ctrl.fn),
      .b_inv    (ctrl.b_inv),
      .nor_mode (ctrl.nor_mode),
      .r_o      (slice_r[i]),
      .c_o      (chain[i+1])
    );
  end

  alu_ovf_flag u_ovf (
    .c_into_top (chain[TOP]),
    .c_out_top  (chain[WIDTH]),
    .arith      (ctrl.arith),
    .signed_en  (signed_en),
    .ovf        (ovf_d)
  );

  assign res_d   = ctrl.legal ? slice_r : '0;
  assign carry_d = ctrl.arith & chain[WIDTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      result_o <= '0;
      carry_o  <= 1'b0;
      ovf_o    <= 1'b0;
    end else begin
      result_o <= res_d;
      carry_o  <= carry_d;
      ovf_o    <= ovf_d;
    end
  end

  // ---------------- assertions ----------------
  assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (result_o == '0 && !carry_o && !ovf_o));

  assert_add_sum_R3: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(op_code) == OPC_ADD) |->
      ({carry_o, result_o} == ({1'b0, $past(opa)} + {1'b0, $past(opb)})));

  assert_sub_carry_R4: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(op_code) == OPC_SUB) |->
      (carry_o == ($past(opa) >= $past(opb))));

  assert_logic_flags_R9: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && ($past(op_code) == OPC_AND || $past(op_code) == OPC_OR ||
                     $past(op_code) == OPC_XOR || $past(op_code) == OPC_NOR)) |->
      (!carry_o && !ovf_o));

  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(signed_en)) |-> !ovf_o);

  assert_unused_zero_R10: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && ($past(op_code) == 4'd5 || $past(op_code) > 4'd6)) |->
      (result_o == '0 && !carry_o && !ovf_o));

endmodule

// File: tb/int_alu_bench.sv
module int_alu_bench;

  localparam int W = 32;

  typedef struct {
    logic [W-1:0] res;
    logic         cy;
    logic         ov;
    logic [3:0]   op;
    logic         rs;
  } exp_t;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [3:0]   op_code = 4'd0;
  logic         signed_en = 1'b0;
  logic [W-1:0] opa = '0;
  logic [W-1:0] opb = '0;
  logic [W-1:0] result_o;
  logic         carry_o;
  logic         ovf_o;

  int n_run  = 0;
  int n_fail = 0;
  bit finished = 1'b0;
  exp_t sb[$];

  always #10 clk = ~clk;  // 50 MHz

  int_alu #(.WIDTH(W)) u_int_alu (
    .clk(clk), .rst(rst), .op_code(op_code), .signed_en(signed_en),
    .opa(opa), .opb(opb), .result_o(result_o), .carry_o(carry_o), .ovf_o(ovf_o)
  );

  function automatic exp_t model(input logic [3:0] op, input logic sg,
                                 input logic [W-1:0] a, input logic [W-1:0] b,
                                 input logic r);
    exp_t e;
    logic [W:0] s;
    e.res = '0; e.cy = 1'b0; e.ov = 1'b0; e.op = op; e.rs = r;
    if (r) return e;                                   // R1
    case (op)
      4'd0: e.res = a & b;                             // R5
      4'd1: e.res = a | b;                             // R5
      4'd3: e.res = a ^ b;                             // R6
      4'd4: e.res = ~(a | b);                          // R6
      4'd2: begin                                      // R3, R7
        s = {1'b0, a} + {1'b0, b};
        e.res = s[W-1:0]; e.cy = s[W];
        e.ov = sg && (a[W-1] == b[W-1]) && (s[W-1] != a[W-1]);
      end
      4'd6: begin                                      // R4, R7
        e.res = a - b; e.cy = (a >= b);
        e.ov = sg && (a[W-1] != b[W-1]) && (e.res[W-1] != a[W-1]);
      end
      default: ;                                       // R10
    endcase
    return e;
  endfunction

  function automatic string req_of(input exp_t e);
    if (e.rs) return "R1";
    case (e.op)
      4'd0, 4'd1: return "R2/R5/R9";
      4'd2:       return "R2/R3/R7/R8";
      4'd6:       return "R2/R4/R7/R8";
      4'd3, 4'd4: return "R2/R6/R9";
      default:    return "R2/R10";
    endcase
  endfunction

  task automatic drive(input logic [3:0] op, input logic sg,
                       input logic [W-1:0] a, input logic [W-1:0] b,
                       input logic r = 1'b0);
    @(negedge clk);
    rst = r; op_code = op; signed_en = sg; opa = a; opb = b;
    sb.push_back(model(op, sg, a, b, r));
  endtask

  // monitor: compares just after the edge that captured the item
  always @(posedge clk) begin
    #1;
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      n_run++;
      if (result_o !== e.res || carry_o !== e.cy || ovf_o !== e.ov) begin
        n_fail++;
        $display("FAIL %s op=%0d: got res=%h cy=%b ov=%b, want res=%h cy=%b ov=%b",
                 req_of(e), e.op, result_o, carry_o, ovf_o, e.res, e.cy, e.ov);
      end
    end
  end

  logic [W-1:0] corner [8] = '{32'h0, 32'h1, 32'hFFFF_FFFF, 32'h7FFF_FFFF,
                              32'h8000_0000, 32'h5555_5555, 32'hAAAA_AAAA, 32'h8000_0001};

  initial begin : watchdog
    repeat (50000) @(posedge clk);
    if (!finished) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: got hung run, want completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin : stim
    // R1: reset state seen at the ports
    repeat (3) @(negedge clk);
    n_run++;
    if (result_o !== '0 || carry_o !== 1'b0 || ovf_o !== 1'b0) begin
      n_fail++;
      $display("FAIL R1 reset: got res=%h cy=%b ov=%b, want 0 0 0", result_o, carry_o, ovf_o);
    end
    // corner operand pairs across every code and both signed settings
    for (int op = 0; op < 16; op++)
      for (int sg = 0; sg < 2; sg++)
        for (int i = 0; i < 8; i++)
          for (int j = 0; j < 8; j++)
            drive(4'(op), 1'(sg), corner[i], corner[j]);
    // R1: reset in the middle of a stream overrides a live add
    drive(4'd2, 1'b1, 32'h7FFF_FFFF, 32'h1, 1'b1);
    drive(4'd6, 1'b1, 32'h8000_0000, 32'h1);
    // targeted overflow edges (R7) and unsigned form (R8)
    drive(4'd2, 1'b1, 32'h7FFF_FFFF, 32'h0000_0001);
    drive(4'd2, 1'b0, 32'h7FFF_FFFF, 32'h0000_0001);
    drive(4'd6, 1'b1, 32'h8000_0000, 32'h0000_0001);
    drive(4'd6, 1'b1, 32'h0000_0000, 32'h8000_0000);
    drive(4'd2, 1'b1, 32'h8000_0000, 32'h8000_0000);
    // random operands
    for (int k = 0; k < 3000; k++)
      drive(4'($urandom_range(0, 15)), 1'($urandom_range(0, 1)), $urandom, $urandom);
    @(negedge clk);
    @(negedge clk);
    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule